// File: doc/BRIEF.md
# Multi-channel pin interrupt detector

This block watches a set of external input pins, one per channel, and turns activity on each pin into an interrupt request. Every pin first goes through a two-stage synchroniser, and edges are found by comparing the synchronised level with its value one clock earlier. Each channel has its own sensing mode. It can stay silent, react to rising edges, falling edges or both, or follow the pin as an active-low or active-high level.

Independent of the mode, every channel records rising and falling edges in two sticky flag registers. Each channel also has a status bit that mirrors its request line. Software reaches everything through a small word-addressed register port. The status and both flag registers are cleared by writing ones. The mode registers can be written and read back. An edge request stays pending until software clears it. A level request has no latch: it tracks the synchronised pin, and a status clear does nothing to it.

Top module: `pin_irq_detect`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), all modes are 0, all rise and fall flags are 0, and every irq_o bit is 0.
- R2: A mode is written at word address 4+ch. Bit 4 selects level (1) or edge (0) sensing. Bit 0 enables rising edges, and only in edge mode. Bit 1 enables falling edges in edge mode; in level mode it selects active-high (1) or active-low (0). Reading the same address returns bits 4, 1 and 0 as written, with every other bit 0. Mode 0x00 never raises a request.
- R3: A rising edge on a pin sets that channel's bit in the rise-flag register at address 1. A falling edge sets the channel's bit in the fall-flag register at address 2. This happens in every mode, and the flag is visible three clock edges after the pin changes.
- R4: Writing a 1 to a flag bit clears it, and writing 0 leaves it alone. Writing all ones clears every channel's flag. A new edge in the same cycle as a clear keeps the flag set.
- R5: In edge modes 0x01, 0x02 and 0x03, a qualifying edge sets a request that stays pending until it is cleared. irq_o[ch] follows that request.
- R6: In level modes 0x10 and 0x12, irq_o[ch] is high while the synchronised pin equals bit 1 of the mode. The request follows the pin two clock edges after the pin changes.
- R7: Writing 1 to a bit of the status register at address 0 clears a pending edge request. For a level channel, that write has no effect. If a qualifying edge arrives in the same cycle as the clear, the request stays set.
- R8: Writing a channel's mode register drops any pending edge request on that channel, so an old edge cannot fire under the new mode.
- R9: Reading address 0 returns the irq_o vector in bits NCH-1:0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| pin_in | input | NCH | Asynchronous external inputs, one per channel |
| bus_we | input | 1 | Register write strobe, sampled at the clock edge |
| bus_addr | input | AW | Word address for both read and write |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data for bus_addr, combinational |
| irq_o | output | NCH | Interrupt request per channel |

## Verification
Two events can land on the same clock edge: a qualifying edge reaching the edge detector, and a software clear of that channel's status or flag. The bench forces this by driving the pin, waiting exactly two clock edges, and holding the clear write across the third edge, which is the edge where the request is captured. It then expects the request and flag still set. A second case applies the clear together with an edge in the direction the mode does not enable, and expects the request cleared. Both cases are repeated with a mode write instead of the clear, to confirm that a mode change drops the pending request.

// File: rtl/pin_irq_pkg.sv
// Shared types and address map for the pin interrupt detector.
// Assumes a word-addressed register port; mode codes are 5-bit values.
package pin_irq_pkg;

    localparam int MODE_W     = 5;
    localparam int ADDR_STAT  = 0;
    localparam int ADDR_RISE  = 1;
    localparam int ADDR_FALL  = 2;
    localparam int ADDR_MODE0 = 4;

    // Stored mode: level select, shared polarity/fall bit, rise enable.
    typedef struct packed {
        logic lvl;
        logic fall_hi;
        logic rise_en;
    } chan_mode_t;

    // Pick the three meaningful bits out of a written code.
    function automatic chan_mode_t decode_mode(input logic [MODE_W-1:0] code);
        chan_mode_t m;
        m.lvl     = code[4];
        m.fall_hi = code[1];
        m.rise_en = code[0];
        return m;
    endfunction

    // Rebuild the readable code from a stored mode.
    function automatic logic [MODE_W-1:0] encode_mode(input chan_mode_t m);
        return {m.lvl, 2'b00, m.fall_hi, m.rise_en};
    endfunction

endpackage

// File: rtl/pin_irq_sync.sv
// Brings NCH asynchronous pins into the clock domain through STAGES flops
// and keeps one more copy for edge detection. Assumes STAGES >= 2.
module pin_irq_sync #(
    parameter int NCH    = 8,
    parameter int STAGES = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] pin_in,
    output logic [NCH-1:0] sync_o,
    output logic [NCH-1:0] rise_o,
    output logic [NCH-1:0] fall_o
);

    logic [NCH-1:0] stage_q [STAGES];
    logic [NCH-1:0] prev_q;

    // Shift the pins through the synchroniser chain and remember the last value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < STAGES; k++) stage_q[k] <= '0;
            prev_q <= '0;
        end else begin
            stage_q[0] <= pin_in;
            for (int k = 1; k < STAGES; k++) stage_q[k] <= stage_q[k-1];
            prev_q <= stage_q[STAGES-1];
        end
    end

    // Edge events come from the synchronised value against its earlier copy.
    always_comb begin
        sync_o = stage_q[STAGES-1];
        rise_o = stage_q[STAGES-1] & ~prev_q;
        fall_o = ~stage_q[STAGES-1] & prev_q;
    end

endmodule

// File: rtl/pin_irq_chan.sv
// One interrupt channel: mode register, rise/fall flags, edge request
// and the request output. Assumes edge inputs are single-cycle pulses.
module pin_irq_chan
    import pin_irq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sync_lvl,
    input  logic       rise_evt,
    input  logic       fall_evt,
    input  logic       mode_we,
    input  chan_mode_t mode_wdata,
    input  logic       rise_clr,
    input  logic       fall_clr,
    input  logic       stat_clr,
    output chan_mode_t mode_o,
    output logic       rise_flag,
    output logic       fall_flag,
    output logic       req_o
);

    chan_mode_t mode_q;
    logic       edge_q;
    logic       edge_hit;

    // Hold the channel mode written by software.
    always_ff @(posedge clk) begin
        if (!rst_n)       mode_q <= '0;
        else if (mode_we) mode_q <= mode_wdata;
    end

    // Sticky edge flags; a new edge wins over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rise_flag <= 1'b0;
            fall_flag <= 1'b0;
        end else begin
            if (rise_evt)      rise_flag <= 1'b1;
            else if (rise_clr) rise_flag <= 1'b0;
            if (fall_evt)      fall_flag <= 1'b1;
            else if (fall_clr) fall_flag <= 1'b0;
        end
    end

    // Decide whether this cycle's edge qualifies under the current mode.
    always_comb begin
        edge_hit = !mode_q.lvl &&
                   ((mode_q.rise_en && rise_evt) || (mode_q.fall_hi && fall_evt));
    end

    // Pending edge request: mode write drops it, a new edge beats a clear.
    always_ff @(posedge clk) begin
        if (!rst_n)        edge_q <= 1'b0;
        else if (mode_we)  edge_q <= 1'b0;
        else if (edge_hit) edge_q <= 1'b1;
        else if (stat_clr) edge_q <= 1'b0;
    end

    // Level channels follow the pin; edge channels show the pending request.
    always_comb begin
        req_o  = mode_q.lvl ? (sync_lvl == mode_q.fall_hi) : edge_q;
        mode_o = mode_q;
    end

endmodule

// File: rtl/pin_irq_detect.sv
// Top level: synchroniser, register decode, per-channel logic and read mux.
// Assumes NCH <= DW and that every mode address fits in AW bits.
module pin_irq_detect
    import pin_irq_pkg::*;
#(
    parameter int NCH    = 8,
    parameter int STAGES = 2,
    parameter int AW     = 4,
    parameter int DW     = 32
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] pin_in,
    input  logic           bus_we,
    input  logic [AW-1:0]  bus_addr,
    input  logic [DW-1:0]  bus_wdata,
    output logic [DW-1:0]  bus_rdata,
    output logic [NCH-1:0] irq_o
);

    localparam logic [AW-1:0] A_STAT = AW'(ADDR_STAT);
    localparam logic [AW-1:0] A_RISE = AW'(ADDR_RISE);
    localparam logic [AW-1:0] A_FALL = AW'(ADDR_FALL);

    logic [NCH-1:0] sync_q, rise_evt, fall_evt;
    logic [NCH-1:0] rise_vec, fall_vec;
    logic [NCH-1:0] rise_clr, fall_clr, stat_clr, mode_we;
    logic [NCH-1:0] lvl_mode, en_a, en_b;
    chan_mode_t     mode_q [NCH];
    chan_mode_t     mode_wr;
    logic           unused_wdata_hi;

    pin_irq_sync #(.NCH(NCH), .STAGES(STAGES)) sync_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_in (pin_in),
        .sync_o (sync_q),
        .rise_o (rise_evt),
        .fall_o (fall_evt)
    );

    // Turn write strobes into per-channel clear masks.
    always_comb begin
        stat_clr = (bus_we && bus_addr == A_STAT) ? bus_wdata[NCH-1:0] : '0;
        rise_clr = (bus_we && bus_addr == A_RISE) ? bus_wdata[NCH-1:0] : '0;
        fall_clr = (bus_we && bus_addr == A_FALL) ? bus_wdata[NCH-1:0] : '0;
        mode_wr  = decode_mode(bus_wdata[MODE_W-1:0]);
        unused_wdata_hi = ^bus_wdata[DW-1:NCH];
    end

    for (genvar i = 0; i < NCH; i++) begin : g_chan
        localparam logic [AW-1:0] A_MODE = AW'(ADDR_MODE0 + i);

        assign mode_we[i]  = bus_we && (bus_addr == A_MODE);
        assign lvl_mode[i] = mode_q[i].lvl;
        assign en_a[i]     = mode_q[i].rise_en;
        assign en_b[i]     = mode_q[i].fall_hi;

        pin_irq_chan chan_i (
            .clk        (clk),
            .rst_n      (rst_n),
            .sync_lvl   (sync_q[i]),
            .rise_evt   (rise_evt[i]),
            .fall_evt   (fall_evt[i]),
            .mode_we    (mode_we[i]),
            .mode_wdata (mode_wr),
            .rise_clr   (rise_clr[i]),
            .fall_clr   (fall_clr[i]),
            .stat_clr   (stat_clr[i]),
            .mode_o     (mode_q[i]),
            .rise_flag  (rise_vec[i]),
            .fall_flag  (fall_vec[i]),
            .req_o      (irq_o[i])
        );
    end

    // Return the register selected by the address.
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_STAT:  bus_rdata[NCH-1:0] = irq_o;
            A_RISE:  bus_rdata[NCH-1:0] = rise_vec;
            A_FALL:  bus_rdata[NCH-1:0] = fall_vec;
            default: begin
                for (int i = 0; i < NCH; i++)
                    if (bus_addr == AW'(ADDR_MODE0 + i))
                        bus_rdata[MODE_W-1:0] = encode_mode(mode_q[i]);
            end
        endcase
    end

endmodule

// File: rtl/pin_irq_detect_chk.sv
// Property checker for pin_irq_detect, attached with bind below.
// Assumes it observes the top's internal event and clear vectors.
module pin_irq_detect_chk #(
    parameter int NCH = 8
) (
    input logic           clk,
    input logic           rst_n,
    input logic [NCH-1:0] irq,
    input logic [NCH-1:0] rise_evt,
    input logic [NCH-1:0] fall_evt,
    input logic [NCH-1:0] rise_vec,
    input logic [NCH-1:0] fall_vec,
    input logic [NCH-1:0] rise_clr,
    input logic [NCH-1:0] fall_clr,
    input logic [NCH-1:0] stat_clr,
    input logic [NCH-1:0] mode_we,
    input logic [NCH-1:0] lvl_mode,
    input logic [NCH-1:0] en_a,
    input logic [NCH-1:0] en_b
);

    for (genvar i = 0; i < NCH; i++) begin : g_prop
        // R3
        rise_flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
            rise_evt[i] |=> rise_vec[i]);
        // R3
        fall_flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
            fall_evt[i] |=> fall_vec[i]);
        // R4
        rise_flag_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
            rise_clr[i] && !rise_evt[i] |=> !rise_vec[i]);
        // R4
        fall_flag_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
            fall_clr[i] && !fall_evt[i] |=> !fall_vec[i]);
        // R7
        clear_collision_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !lvl_mode[i] && en_a[i] && rise_evt[i] && stat_clr[i] && !mode_we[i] |=> irq[i]);
        // R8
        mode_change_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
            mode_we[i] |=> (lvl_mode[i] || !irq[i]));
        // R2
        silent_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
            irq[i] |-> (lvl_mode[i] || en_a[i] || en_b[i]));
    end

endmodule

bind pin_irq_detect pin_irq_detect_chk #(.NCH(NCH)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .irq      (irq_o),
    .rise_evt (rise_evt),
    .fall_evt (fall_evt),
    .rise_vec (rise_vec),
    .fall_vec (fall_vec),
    .rise_clr (rise_clr),
    .fall_clr (fall_clr),
    .stat_clr (stat_clr),
    .mode_we  (mode_we),
    .lvl_mode (lvl_mode),
    .en_a     (en_a),
    .en_b     (en_b)
);

// File: tb/pin_irq_detect_tb.sv
`timescale 1ns/1ps
module pin_irq_detect_tb_top;

    localparam int NCH = 8;
    localparam int AW  = 4;
    localparam int DW  = 32;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [NCH-1:0] pin_in = '0;
    logic           bus_we = 1'b0;
    logic [AW-1:0]  bus_addr = '0;
    logic [DW-1:0]  bus_wdata = '0;
    logic [DW-1:0]  bus_rdata;
    logic [NCH-1:0] irq_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    pin_irq_detect #(.NCH(NCH), .AW(AW), .DW(DW)) dut_i (
        .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_o(irq_o)
    );

    task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [DW-1:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = AW'(a); bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input int a, output logic [DW-1:0] d);
        @(negedge clk);
        bus_addr = AW'(a);
        #1 d = bus_rdata;
    endtask

    task automatic set_pins(input logic [NCH-1:0] v);
        @(negedge clk);
        pin_in = v;
        repeat (4) @(negedge clk);
    endtask

    // Drive pins, then hold a write across the third edge, where the edge is captured.
    task automatic pin_with_write(input logic [NCH-1:0] v, input int a, input logic [DW-1:0] d);
        @(negedge clk);
        pin_in = v;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = AW'(a); bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : stim
        logic [DW-1:0] d;
        logic [4:0] codes [6] = '{5'h00, 5'h01, 5'h02, 5'h03, 5'h10, 5'h12};

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        @(negedge clk);
        check("R1 irq", DW'(irq_o), '0);
        rd(1, d); check("R1 rise flags", d, '0);
        rd(2, d); check("R1 fall flags", d, '0);
        rd(4, d); check("R1 mode0", d, '0);

        // Sweep every channel through every mode with a rise then a fall.
        for (int ch = 0; ch < NCH; ch++) begin
            for (int mi = 0; mi < 6; mi++) begin
                logic [4:0] m = codes[mi];
                logic lvl = m[4], b1 = m[1], b0 = m[0];
                logic [NCH-1:0] one = NCH'(1) << ch;
                wr(4 + ch, DW'(m));
                wr(1, '1);
                wr(2, '1);
                @(negedge clk); #1;
                check("R6 idle low pin", DW'(irq_o), DW'((lvl && !b1) ? one : '0));
                set_pins(one);
                check("R5/R6 after rise", DW'(irq_o), DW'((lvl ? b1 : b0) ? one : '0));
                rd(1, d); check("R3 rise flag", d, DW'(one));
                wr(0, '1);
                check("R7 status clear after rise", DW'(irq_o), DW'((lvl && b1) ? one : '0));
                set_pins('0);
                check("R5/R6 after fall", DW'(irq_o), DW'((lvl ? !b1 : (!lvl && b1)) ? one : '0));
                rd(2, d); check("R3 fall flag", d, DW'(one));
                wr(0, '1);
                check("R7 status clear after fall", DW'(irq_o), DW'((lvl && !b1) ? one : '0));
                rd(0, d); check("R9 status read", d, DW'(irq_o));
                wr(4 + ch, '0);
                @(negedge clk);
                check("R2 mode 0 silent", DW'(irq_o), '0);
            end
        end

        // R2: mode readback keeps bits 4,1,0 only
        wr(5, DW'(32'hFF));
        rd(5, d); check("R2 mode readback", d, DW'(5'h13));
        wr(5, '0);

        // All channels on both edges with a mixed pattern.
        for (int ch = 0; ch < NCH; ch++) wr(4 + ch, DW'(5'h03));
        wr(1, '1); wr(2, '1); wr(0, '1);
        set_pins(8'hA5);
        check("R5 both edges multi", DW'(irq_o), DW'(8'hA5));
        rd(0, d); check("R9 status word", d, DW'(8'hA5));
        // R4: writing zeros keeps flags; partial ones clears only those
        wr(1, '0);
        rd(1, d); check("R4 write zero keeps", d, DW'(8'hA5));
        wr(1, DW'(8'h05));
        rd(1, d); check("R4 partial clear", d, DW'(8'hA0));
        wr(1, '1);
        rd(1, d); check("R4 clear all", d, '0);
        wr(0, DW'(8'h0F));
        check("R7 partial status clear", DW'(irq_o), DW'(8'hA0));
        wr(0, '1);
        set_pins('0);
        rd(2, d); check("R3 fall flags multi", d, DW'(8'hA5));
        wr(2, '1); wr(0, '1);

        // R7: clear lands together with a qualifying rising edge -> stays set
        wr(4, DW'(5'h01));
        pin_with_write(8'h01, 0, DW'(1));
        check("R7 collision edge wins", DW'(irq_o[0]), DW'(1));
        // R4: flag clear colliding with a fresh edge keeps the flag
        wr(2, '1);
        pin_with_write(8'h00, 2, DW'(1));
        rd(2, d); check("R4 flag collision", d & DW'(1), DW'(1));
        // R7: clear with a non-qualifying falling edge -> cleared
        set_pins(8'h01);
        pin_with_write(8'h00, 0, DW'(1));
        check("R7 clear with other edge", DW'(irq_o[0]), '0);

        // R8: mode change drops pending edge request
        wr(4, DW'(5'h01));
        set_pins(8'h01);
        check("R8 pending before", DW'(irq_o[0]), DW'(1));
        wr(4, DW'(5'h02));
        check("R8 dropped by mode write", DW'(irq_o[0]), '0);
        // R8: mode write in the capture cycle of a qualifying edge also drops it
        pin_with_write(8'h00, 4, DW'(5'h02));
        check("R8 mode write beats edge", DW'(irq_o[0]), '0);
        wr(4, '0);

        // R6: level channel ignores status clear while pin holds
        wr(6, DW'(5'h12));
        set_pins(8'h04);
        wr(0, '1);
        check("R6 level ignores clear", DW'(irq_o[2]), DW'(1));
        // R6: level follows the pin after two edges
        @(negedge clk); pin_in = 8'h00;
        @(negedge clk);
        check("R6 not yet after one edge", DW'(irq_o[2]), DW'(1));
        @(negedge clk);
        check("R6 follows after two edges", DW'(irq_o[2]), '0);
        wr(6, '0);

        // R1: reset in the middle clears everything
        wr(4, DW'(5'h10));
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        check("R1 irq after reset", DW'(irq_o), '0);
        rd(4, d); check("R1 mode after reset", d, '0);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule